// File: doc/BRIEF.md
# Self-Timed Program and Erase Sequencer

This block sits behind the serial command decoder of a small nonvolatile word store. The decoder hands it each write-class command once the last bit has been shifted in. The sequencer holds the write-enable latch, waits for chip select to drop in the one legal gap, and then runs a self-timed internal cycle. During that cycle it drives the word array's write port and raises a busy flag that the front end reports to the host.

A single-word program always clears the word to all ones first and then stores the new data, so the host never has to erase before a program. Whole-array clear and whole-array fill step through every address in ascending order. The fill does a complete clear sweep before its data sweep. The cycle length is a parameter counted in system-clock cycles, so no serial clock activity is needed while the cycle runs.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, busy_o, wel_o and mem_we_o are all 0.
- R2: A command with cmd_op_i = 4 (enable) sets wel_o, and a command with cmd_op_i = 5 (disable) clears it. wel_o keeps its value at all other times.
- R3: A program command arriving while wel_o is 0 is dropped. Program commands are cmd_op_i = 0 (word write), 1 (word clear), 2 (clear all) and 3 (fill all). A dropped command causes no busy and no array write.
- R4: An accepted program command becomes armed on the clock after cmd_valid_i. busy_o rises on the clock after the first cycle in which the command is armed, cs_i is 0 and sk_rise_i is 0. The command stays armed for as long as cs_i stays 1 and no sk_rise_i arrives.
- R5: If sk_rise_i arrives while the command is armed, the command is dropped. This includes the cycle in which cs_i first reads 0. A dropped command causes no busy and no array write.
- R6: A word clear makes exactly one array write, of all ones, to the given address.
- R7: A word write makes two array writes to the given address in consecutive cycles. The first writes all ones and the second writes the data.
- R8: A clear-all writes all ones to every address, one per cycle, in ascending order from 0.
- R9: A fill-all first writes all ones to every address in ascending order. It then writes the data to every address in ascending order.
- R10: busy_o stays high for exactly CYCLE_CLKS cycles when all array writes fit in that time. Otherwise it stays high until the cycle after the last array write.
- R11: mem_we_o is only ever 1 while busy_o is 1.
- R12: Commands of any kind that arrive while busy_o is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle pulse: a decoded command is complete |
| cmd_op_i | input | 3 | Command code (see R2, R3) |
| cmd_addr_i | input | ADDR_W | Word address of the command |
| cmd_data_i | input | DATA_W | Data word of the command |
| cs_i | input | 1 | Chip select level, synchronised |
| sk_rise_i | input | 1 | One-cycle pulse on each serial clock rising edge |
| busy_o | output | 1 | Internal cycle in progress |
| wel_o | output | 1 | Write-enable latch state |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The falling chip select and a serial clock rising edge can land in the same system clock. The start rule then has to choose between starting the cycle and dropping the command. The bench provokes this by driving cs_i low and pulsing sk_rise_i on the same edge while a word write is armed. It judges the result as a drop: busy_o never rises and no array write appears. A second collision is a new command arriving while the sweep is running. That command must leave both the latch and the write log untouched.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;
  typedef enum logic [2:0] {
    OP_WRITE     = 3'd0,
    OP_CLEAR     = 3'd1,
    OP_CLEAR_ALL = 3'd2,
    OP_FILL_ALL  = 3'd3,
    OP_ENABLE    = 3'd4,
    OP_DISABLE   = 3'd5
  } pe_op_e;
endpackage

// File: rtl/pe_write_latch.sv
module pe_write_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wel_q <= 1'b0;
    else if (clr_i) wel_q <= 1'b0;
    else if (set_i) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  p_wel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(wel_q));
  p_wel_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> wel_q);
endmodule

// File: rtl/pe_start_window.sv
module pe_start_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cs_i,
  input  logic sk_rise_i,
  output logic armed_o,
  output logic start_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              armed_q <= 1'b0;
    else if (arm_i)                           armed_q <= 1'b1;
    else if (armed_q && (sk_rise_i || !cs_i)) armed_q <= 1'b0;
  end

  // a clock edge in the same cycle as the CS drop counts as late
  assign start_o = armed_q && !cs_i && !sk_rise_i;
  assign armed_o = armed_q;

  p_late_edge_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && sk_rise_i && !arm_i) |=> !armed_q);
  p_wait_while_cs_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cs_i && !sk_rise_i) |=> armed_q);
endmodule

// File: rtl/pe_cycle_engine.sv
module pe_cycle_engine #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sweep_i,
  input  logic              program_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int TMR_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CYCLE_CLKS - 1);

  logic              busy_q, pass_q, sweep_q, prog_q, done_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [DATA_W-1:0] data_q;
  logic [TMR_W-1:0]  tmr_q;
  logic upd_active, last_addr, last_upd, tmr_end, finish;

  always_comb begin
    upd_active = busy_q && !done_q;
    last_addr  = !sweep_q || (addr_q == '1);
    last_upd   = last_addr && (pass_q || !prog_q);
    tmr_end    = (tmr_q == TMR_LAST);
    finish     = busy_q && tmr_end && (done_q || last_upd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pass_q  <= 1'b0;
      sweep_q <= 1'b0;
      prog_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      data_q  <= '0;
      tmr_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      pass_q  <= 1'b0;
      sweep_q <= sweep_i;
      prog_q  <= program_i;
      done_q  <= 1'b0;
      addr_q  <= sweep_i ? '0 : addr_i;
      base_q  <= addr_i;
      data_q  <= data_i;
      tmr_q   <= '0;
    end else if (busy_q) begin
      if (finish)   busy_q <= 1'b0;
      if (!tmr_end) tmr_q  <= tmr_q + 1'b1;
      if (upd_active) begin
        if (last_upd)       done_q <= 1'b1;
        else if (!last_addr) addr_q <= addr_q + 1'b1;
        else begin
          // clear pass finished, begin program pass
          pass_q <= 1'b1;
          addr_q <= sweep_q ? '0 : base_q;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign mem_we_o    = upd_active;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pass_q ? data_q : '1;

  p_busy_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(tmr_q) == TMR_LAST));
  p_sweep_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_active && $past(upd_active) && sweep_q && (pass_q == $past(pass_q)))
      |-> (addr_q == $past(addr_q) + 1'b1));
  p_clear_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> ($past(mem_we_o) && ($past(mem_wdata_o) == '1)));
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_seq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  output logic              busy_o,
  output logic              wel_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  pe_op_e            op, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic idle, armed, start, is_prog, arm, wel_set, wel_clr, busy, wel;

  assign op = pe_op_e'(cmd_op_i);

  always_comb begin
    idle    = !busy && !armed;
    is_prog = (op == OP_WRITE) || (op == OP_CLEAR) ||
              (op == OP_CLEAR_ALL) || (op == OP_FILL_ALL);
    arm     = cmd_valid_i && idle && is_prog && wel;
    wel_set = cmd_valid_i && idle && (op == OP_ENABLE);
    wel_clr = cmd_valid_i && idle && (op == OP_DISABLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else if (arm) begin
      op_q   <= op;
      addr_q <= cmd_addr_i;
      data_q <= cmd_data_i;
    end
  end

  pe_write_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wel_set),
    .clr_i  (wel_clr),
    .wel_o  (wel)
  );

  pe_start_window u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .cs_i      (cs_i),
    .sk_rise_i (sk_rise_i),
    .armed_o   (armed),
    .start_o   (start)
  );

  pe_cycle_engine #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .sweep_i     ((op_q == OP_CLEAR_ALL) || (op_q == OP_FILL_ALL)),
    .program_i   ((op_q == OP_WRITE) || (op_q == OP_FILL_ALL)),
    .addr_i      (addr_q),
    .data_i      (data_q),
    .busy_o      (busy),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign busy_o = busy;
  assign wel_o  = wel;

  p_we_inside_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  p_locked_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wel_o);
  p_start_on_cs_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!cs_i && !sk_rise_i));
  p_busy_blocks_latch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(wel_o));
endmodule

// File: tb/pe_sequencer_test.sv
module pe_sequencer_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CYC = 300;
  localparam int WORDS = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = 3'd0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] cmd_data_i = '0;
  logic cs_i = 1'b0;
  logic sk_rise_i = 1'b0;
  logic busy_o, wel_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  int busy_cyc = 0;
  int stray_we = 0;
  int cyc_total = 0;
  logic [AW-1:0] wr_a [256];
  logic [DW-1:0] wr_d [256];
  logic [DW-1:0] model [WORDS];

  pe_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .cs_i(cs_i), .sk_rise_i(sk_rise_i),
    .busy_o(busy_o), .wel_o(wel_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc_total++;
    if (rst_ni) begin
      if (busy_o) busy_cyc++;
      if (mem_we_o) begin
        if (!busy_o) stray_we++;
        model[mem_addr_o] = mem_wdata_o;
        if (wr_cnt < 256) begin
          wr_a[wr_cnt] = mem_addr_o;
          wr_d[wr_cnt] = mem_wdata_o;
        end
        wr_cnt++;
      end
    end
    if (cyc_total > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk_i);
    wr_cnt = 0;
    busy_cyc = 0;
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    cs_i = 1'b1;
    cmd_valid_i = 1'b1;
    cmd_op_i = op;
    cmd_addr_i = a;
    cmd_data_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk_i);
    cs_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run_prog(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    clear_log();
    send_cmd(op, a, d);
    cs_i = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(wel_o == 1'b0, "R1 wel", wel_o, 0);
    check(mem_we_o == 1'b0, "R1 we", mem_we_o, 0);
  endtask

  task automatic t_locked();
    run_prog(3'd0, 6'd5, 16'hA5A5);
    check(wr_cnt == 0, "R3 writes", wr_cnt, 0);
    check(busy_cyc == 0, "R3 busy", busy_cyc, 0);
    check(model[5] == 16'h0, "R3 word", model[5], 0);
  endtask

  task automatic t_enable();
    send_cmd(3'd4, '0, '0);
    @(negedge clk_i);
    check(wel_o == 1'b1, "R2 enable", wel_o, 1);
  endtask

  task automatic t_write_timing();
    clear_log();
    send_cmd(3'd0, 6'd5, 16'hA5A5);
    repeat (20) @(negedge clk_i);
    check(busy_o == 1'b0, "R4 waits while cs high", busy_o, 0);
    cs_i = 1'b0;
    @(negedge clk_i);
    check(busy_o == 1'b1, "R4 busy after cs drop", busy_o, 1);
    wait_idle();
    check(wr_cnt == 2, "R7 write count", wr_cnt, 2);
    check(wr_a[0] == 6'd5 && wr_a[1] == 6'd5, "R7 addr", wr_a[1], 5);
    check(wr_d[0] == 16'hFFFF, "R7 clear first", wr_d[0], 16'hFFFF);
    check(wr_d[1] == 16'hA5A5, "R7 data second", wr_d[1], 16'hA5A5);
    check(model[5] == 16'hA5A5, "R7 word", model[5], 16'hA5A5);
    check(busy_cyc == CYC, "R10 busy length", busy_cyc, CYC);
    check(wel_o == 1'b1, "R2 latch holds", wel_o, 1);
  endtask

  task automatic t_clear();
    run_prog(3'd1, 6'd5, 16'h1111);
    check(wr_cnt == 1, "R6 count", wr_cnt, 1);
    check(wr_a[0] == 6'd5, "R6 addr", wr_a[0], 5);
    check(model[5] == 16'hFFFF, "R6 word", model[5], 16'hFFFF);
  endtask

  task automatic t_late_edge(input bit same_cycle);
    clear_log();
    send_cmd(3'd0, 6'd9, 16'h4242);
    sk_rise_i = 1'b1;
    if (same_cycle) cs_i = 1'b0;
    @(negedge clk_i);
    sk_rise_i = 1'b0;
    cs_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check(busy_cyc == 0, "R5 no busy", busy_cyc, 0);
    check(wr_cnt == 0, "R5 no writes", wr_cnt, 0);
    check(model[9] == 16'h0, "R5 word", model[9], 0);
    cs_i = 1'b1;
  endtask

  task automatic t_fill_all();
    int bad;
    run_prog(3'd3, '0, 16'h1357);
    check(wr_cnt == 2 * WORDS, "R9 count", wr_cnt, 2 * WORDS);
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      if (wr_a[i] != AW'(i) || wr_d[i] != 16'hFFFF) bad++;
      if (wr_a[WORDS + i] != AW'(i) || wr_d[WORDS + i] != 16'h1357) bad++;
      if (model[i] != 16'h1357) bad++;
    end
    check(bad == 0, "R9 sweeps", bad, 0);
    check(busy_cyc == CYC, "R10 busy fill", busy_cyc, CYC);
  endtask

  task automatic t_clear_all();
    int bad;
    run_prog(3'd2, '0, '0);
    check(wr_cnt == WORDS, "R8 count", wr_cnt, WORDS);
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      if (wr_a[i] != AW'(i) || wr_d[i] != 16'hFFFF) bad++;
      if (model[i] != 16'hFFFF) bad++;
    end
    check(bad == 0, "R8 ascending ones", bad, 0);
  endtask

  task automatic t_busy_ignore();
    clear_log();
    send_cmd(3'd2, '0, '0);
    cs_i = 1'b0;
    repeat (10) @(negedge clk_i);
    send_cmd(3'd5, '0, '0);
    send_cmd(3'd0, 6'd3, 16'h0BAD);
    cs_i = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk_i);
    check(wel_o == 1'b1, "R12 latch kept", wel_o, 1);
    check(wr_cnt == WORDS, "R12 no extra writes", wr_cnt, WORDS);
    check(model[3] == 16'hFFFF, "R12 word", model[3], 16'hFFFF);
  endtask

  task automatic t_disable();
    send_cmd(3'd5, '0, '0);
    @(negedge clk_i);
    check(wel_o == 1'b0, "R2 disable", wel_o, 0);
    run_prog(3'd1, 6'd7, '0);
    check(wr_cnt == 0, "R3 after disable", wr_cnt, 0);
    model[7] = 16'h0;
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_locked();
    t_enable();
    t_write_timing();
    t_clear();
    t_late_edge(1'b0);
    t_late_edge(1'b1);
    t_fill_all();
    t_clear_all();
    t_busy_ignore();
    t_disable();
    check(stray_we == 0, "R11 writes outside busy", stray_we, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule